// File: doc/BRIEF.md
# Exact-Match MAC Address Filter Bank

The block holds a bank of seven programmable 48-bit Ethernet address entries. Each entry has a valid flag and a two-bit select code. The select code decides whether the entry is compared with the destination address or with the source address of a frame. Software reaches each entry through a 32-bit register port as a low word and a high word. A parallel header interface presents each frame's destination and source addresses. One cycle later the block reports whether an enabled entry matched, and which one.

After reset the block checks whether an external non-volatile memory is present. If it is, the block reads three 16-bit words from it over a request/acknowledge handshake and fills entry 0 with the station address. Register writes wait until this load has finished.

Top module: `mac_addr_filter`

## Requirements
- R1: Entry n (n = 0..6) has its low word at register slot 4n and its high word at slot 4n+2. The low word holds address bits 31:0. In the high word, bits 15:0 hold address bits 47:32, bits 17:16 hold the select code and bit 31 holds the valid flag. Any other slot reads as zero and ignores writes.
- R2: Bits 30:18 of every high word read as zero, and values written to them are discarded.
- R3: Reset clears the valid flag of every entry. When no memory is present, entry 0 also stays invalid and reg_ready is high by the second clock after reset is released.
- R4: When memory is present, the block makes three reads in the order word 0, word 1, word 2. Each read holds nvm_req and a stable nvm_addr until nvm_ack. Word 0 supplies address bits 15:0, word 1 supplies bits 31:16 and word 2 supplies bits 47:32. After the last acknowledge, entry 0 holds that address with select code 00 and the valid flag set.
- R5: reg_ready is low from reset until the load has finished. A write presented while reg_ready is low changes no entry until reg_ready rises, and is then applied.
- R6: Select code 00 compares the entry with hdr_dst_mac. Select code 01 compares it with hdr_src_mac.
- R7: An entry with select code 10 or 11 never matches, even when it is valid.
- R8: An entry whose valid flag is clear never matches.
- R9: When several entries match, match_idx reports the lowest-numbered one.
- R10: match_valid, match_hit and match_idx are registered. They reflect the header presented on the previous clock. match_hit is 0 when hdr_valid was low or nothing matched, and match_idx is 0 when there is no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nvm_present | input | 1 | High when a memory image is available |
| nvm_req | output | 1 | Read request to memory |
| nvm_addr | output | 2 | Memory word being read |
| nvm_ack | input | 1 | Read data valid on nvm_data |
| nvm_data | input | 16 | Memory read data |
| reg_wr | input | 1 | Write strobe, held until reg_ready |
| reg_addr | input | 5 | Register slot |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| reg_ready | output | 1 | Writes accepted |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_dst_mac | input | 48 | Frame destination address |
| hdr_src_mac | input | 48 | Frame source address |
| match_valid | output | 1 | A header was presented last cycle |
| match_hit | output | 1 | An enabled entry matched |
| match_idx | output | 3 | Lowest matching entry |

## Verification
The assertions check on every cycle that a pending memory request keeps its address until acknowledged, that reg_ready never falls once raised, and that a stalled write leaves the bank untouched. They also check that no hit is reported without a header, and that any hit names an entry that was valid. Only the bench scenarios can show the register layout and the reserved-bit masking. The same holds for the word order of the memory load, and for the choice between destination and source. Priority among several matching entries, and the effect of reset on previously programmed entries, are likewise shown only by the bench.

// File: rtl/maf_pkg.sv
// Shared constants for the address filter bank.
// Assumes a 48-bit address split into 32-bit low and 16-bit high register halves.
package maf_pkg;
    localparam int MAC_W     = 48;
    localparam int REG_W     = 32;
    localparam int NVM_W     = 16;
    localparam int NVM_WORDS = 3;
    localparam int HI_MAC_W  = MAC_W - REG_W;
    localparam int SEL_LSB   = 16;
    localparam int VLD_BIT   = 31;
    localparam int RSV_W     = VLD_BIT - (SEL_LSB + 2);

    typedef enum logic [1:0] {
        SEL_DST  = 2'b00,
        SEL_SRC  = 2'b01,
        SEL_RSV2 = 2'b10,
        SEL_RSV3 = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        LD_CHECK = 2'b00,
        LD_FETCH = 2'b01,
        LD_DONE  = 2'b10
    } ld_state_e;
endpackage

// File: rtl/maf_nvm_loader.sv
// Reads the station address from non-volatile memory after reset.
// Assumes the memory keeps nvm_data valid in the cycle nvm_ack is high, and
// that nvm_present is stable around reset. ready is high once loading is over.
module maf_nvm_loader
    import maf_pkg::*;
#(
    parameter int WORDS = NVM_WORDS,
    parameter int DW    = NVM_W,
    localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int OW   = WORDS * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nvm_present,
    output logic          nvm_req,
    output logic [AW-1:0] nvm_addr,
    input  logic          nvm_ack,
    input  logic [DW-1:0] nvm_data,
    output logic          load_wr,
    output logic [OW-1:0] load_mac,
    output logic          ready
);
    ld_state_e             state_q;
    logic [AW-1:0]         word_q;
    logic [WORDS-1:0][DW-1:0] buf_q;
    logic                  last_word;

    assign last_word = (word_q == AW'(WORDS - 1));
    assign nvm_req   = (state_q == LD_FETCH);
    assign nvm_addr  = word_q;
    assign ready     = (state_q == LD_DONE);
    assign load_wr   = nvm_req && nvm_ack && last_word;

    // Sequence: decide after reset, fetch each word in turn, then idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_CHECK;
            word_q  <= '0;
        end else begin
            case (state_q)
                LD_CHECK: state_q <= nvm_present ? LD_FETCH : LD_DONE;
                LD_FETCH: if (nvm_ack) begin
                    if (last_word) state_q <= LD_DONE;
                    else           word_q  <= word_q + AW'(1);
                end
                default:  state_q <= LD_DONE;
            endcase
        end
    end

    // Capture each acknowledged word into its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else if (nvm_req && nvm_ack) buf_q[word_q] <= nvm_data;
    end

    // Assemble the address; the final word comes straight from the bus.
    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            if (i == WORDS - 1) load_mac[i*DW +: DW] = nvm_data;
            else                load_mac[i*DW +: DW] = buf_q[i];
        end
    end

    // R4: a pending request keeps its word address until acknowledged.
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (nvm_req && !nvm_ack) |=> (nvm_req && $stable(nvm_addr)));

    // R5: once writes are accepted they stay accepted until the next reset.
    assert_ready_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
endmodule

// File: rtl/maf_entry_bank.sv
// Storage for the address entries and their register view.
// Assumes a write is taken only in a cycle where reg_wr and reg_ready are both
// high; the memory load to entry 0 takes precedence over any register write.
module maf_entry_bank
    import maf_pkg::*;
#(
    parameter int N  = 7,
    parameter int AW = 5,
    localparam int IW = AW - 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic                     reg_ready,
    input  logic [AW-1:0]            reg_addr,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata,
    input  logic                     load_wr,
    input  logic [MAC_W-1:0]         load_mac,
    output logic [N-1:0][MAC_W-1:0]  e_mac,
    output logic [N-1:0][1:0]        e_sel,
    output logic [N-1:0]             e_vld
);
    logic [IW-1:0] slot_idx;
    logic          slot_lo;
    logic          slot_hi;
    logic          slot_ok;
    logic          wr_take;
    logic          unused_rsv;

    assign slot_idx   = reg_addr[AW-1:2];
    assign slot_lo    = (reg_addr[1:0] == 2'b00);
    assign slot_hi    = (reg_addr[1:0] == 2'b10);
    assign slot_ok    = (32'(slot_idx) < N);
    assign wr_take    = reg_wr && reg_ready && slot_ok;
    assign unused_rsv = ^reg_wdata[VLD_BIT-1:SEL_LSB+2];

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic sel_me;
        assign sel_me = wr_take && (slot_idx == IW'(i));

        // Per-entry update: reset, memory load (entry 0 only), register write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_mac[i] <= '0;
                e_sel[i] <= SEL_DST;
                e_vld[i] <= 1'b0;
            end else if (i == 0 && load_wr) begin
                e_mac[i] <= load_mac;
                e_sel[i] <= SEL_DST;
                e_vld[i] <= 1'b1;
            end else if (sel_me && slot_lo) begin
                e_mac[i][REG_W-1:0] <= reg_wdata;
            end else if (sel_me && slot_hi) begin
                e_mac[i][MAC_W-1:REG_W] <= reg_wdata[HI_MAC_W-1:0];
                e_sel[i] <= reg_wdata[SEL_LSB +: 2];
                e_vld[i] <= reg_wdata[VLD_BIT];
            end
        end
    end

    // Read view: low half, packed high half, or zero for unmapped slots.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (slot_ok && slot_idx == IW'(i)) begin
                if (slot_lo)
                    reg_rdata = e_mac[i][REG_W-1:0];
                else if (slot_hi)
                    reg_rdata = {e_vld[i], {RSV_W{1'b0}}, e_sel[i],
                                 e_mac[i][MAC_W-1:REG_W]};
            end
        end
    end

    // R5: a write held while not ready leaves every entry unchanged.
    assert_stall_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_ready && !load_wr) |=>
            ($stable(e_mac) && $stable(e_sel) && $stable(e_vld)));
endmodule

// File: rtl/maf_matcher.sv
// Compares a presented header with every enabled entry and registers the
// lowest-numbered hit. Assumes headers are presented for one cycle each.
module maf_matcher
    import maf_pkg::*;
#(
    parameter int N   = 7,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hdr_valid,
    input  logic [MAC_W-1:0]         hdr_dst_mac,
    input  logic [MAC_W-1:0]         hdr_src_mac,
    input  logic [N-1:0][MAC_W-1:0]  e_mac,
    input  logic [N-1:0][1:0]        e_sel,
    input  logic [N-1:0]             e_vld,
    output logic                     match_valid,
    output logic                     match_hit,
    output logic [IW-1:0]            match_idx
);
    logic [N-1:0]  hit_vec;
    logic [IW-1:0] first_idx;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic dst_eq;
        logic src_eq;
        assign dst_eq = (e_mac[i] == hdr_dst_mac);
        assign src_eq = (e_mac[i] == hdr_src_mac);
        assign hit_vec[i] = e_vld[i] &&
            (((e_sel[i] == SEL_DST) && dst_eq) || ((e_sel[i] == SEL_SRC) && src_eq));
    end

    // Priority pick: scanning downward leaves the lowest hit index.
    always_comb begin
        first_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) first_idx = IW'(i);
        end
    end

    // Result register, one cycle after the header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_valid <= 1'b0;
            match_hit   <= 1'b0;
            match_idx   <= '0;
        end else begin
            match_valid <= hdr_valid;
            match_hit   <= hdr_valid && (|hit_vec);
            match_idx   <= (hdr_valid && (|hit_vec)) ? first_idx : '0;
        end
    end

    // R10: with no header last cycle there is no result.
    assert_no_hdr_no_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> (!match_hit && !match_valid));

    // R8: a reported hit names an entry that was valid when compared.
    assert_hit_entry_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |-> ((($past(e_vld) >> match_idx) & N'(1)) != '0));
endmodule

// File: rtl/mac_addr_filter.sv
// Top level of the exact-match address filter: memory loader, entry bank and
// matcher. Assumes a single clock domain and a synchronous active-low reset.
module mac_addr_filter
    import maf_pkg::*;
#(
    parameter int N_ENTRIES = 7,
    parameter int RAW       = 5,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int NAW      = (NVM_WORDS > 1) ? $clog2(NVM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nvm_present,
    output logic              nvm_req,
    output logic [NAW-1:0]    nvm_addr,
    input  logic              nvm_ack,
    input  logic [NVM_W-1:0]  nvm_data,
    input  logic              reg_wr,
    input  logic [RAW-1:0]    reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              reg_ready,
    input  logic              hdr_valid,
    input  logic [MAC_W-1:0]  hdr_dst_mac,
    input  logic [MAC_W-1:0]  hdr_src_mac,
    output logic              match_valid,
    output logic              match_hit,
    output logic [IDX_W-1:0]  match_idx
);
    logic                          load_wr;
    logic [MAC_W-1:0]              load_mac;
    logic [N_ENTRIES-1:0][MAC_W-1:0] e_mac;
    logic [N_ENTRIES-1:0][1:0]     e_sel;
    logic [N_ENTRIES-1:0]          e_vld;

    maf_nvm_loader #(.WORDS(NVM_WORDS), .DW(NVM_W)) u_loader (
        .clk(clk), .rst_n(rst_n), .nvm_present(nvm_present),
        .nvm_req(nvm_req), .nvm_addr(nvm_addr), .nvm_ack(nvm_ack),
        .nvm_data(nvm_data), .load_wr(load_wr), .load_mac(load_mac),
        .ready(reg_ready)
    );

    maf_entry_bank #(.N(N_ENTRIES), .AW(RAW)) u_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ready(reg_ready),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .load_wr(load_wr), .load_mac(load_mac),
        .e_mac(e_mac), .e_sel(e_sel), .e_vld(e_vld)
    );

    maf_matcher #(.N(N_ENTRIES)) u_match (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid),
        .hdr_dst_mac(hdr_dst_mac), .hdr_src_mac(hdr_src_mac),
        .e_mac(e_mac), .e_sel(e_sel), .e_vld(e_vld),
        .match_valid(match_valid), .match_hit(match_hit), .match_idx(match_idx)
    );
endmodule

// File: tb/mac_addr_filter_tb.sv
module mac_addr_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nvm_present = 1'b0;
    logic        nvm_req;
    logic [1:0]  nvm_addr;
    logic        nvm_ack = 1'b0;
    logic [15:0] nvm_data = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_ready;
    logic        hdr_valid = 1'b0;
    logic [47:0] hdr_dst_mac = '0;
    logic [47:0] hdr_src_mac = '0;
    logic        match_valid;
    logic        match_hit;
    logic [2:0]  match_idx;

    int checks = 0;
    int errors = 0;
    int n_reads = 0;
    logic [1:0] seen_addr [3];

    localparam logic [15:0] W0 = 16'h5566;
    localparam logic [15:0] W1 = 16'h3344;
    localparam logic [15:0] W2 = 16'h0A11;
    localparam logic [47:0] STATION = {W2, W1, W0};

    always #4 clk = ~clk;

    mac_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .nvm_present(nvm_present),
        .nvm_req(nvm_req), .nvm_addr(nvm_addr), .nvm_ack(nvm_ack),
        .nvm_data(nvm_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready),
        .hdr_valid(hdr_valid), .hdr_dst_mac(hdr_dst_mac),
        .hdr_src_mac(hdr_src_mac), .match_valid(match_valid),
        .match_hit(match_hit), .match_idx(match_idx)
    );

    // Memory model: acknowledge each request one cycle, record word order.
    always @(negedge clk) begin
        if (nvm_ack) begin
            nvm_ack = 1'b0;
        end else if (nvm_req === 1'b1) begin
            case (nvm_addr)
                2'd0:    nvm_data = W0;
                2'd1:    nvm_data = W1;
                default: nvm_data = W2;
            endcase
            if (n_reads < 3) seen_addr[n_reads] = nvm_addr;
            n_reads++;
            nvm_ack = 1'b1;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(logic present);
        @(negedge clk);
        rst_n = 1'b0;
        nvm_present = present;
        repeat (2) @(negedge clk);
        n_reads = 0;
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        logic rdy;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        forever begin
            rdy = reg_ready;
            @(posedge clk);
            if (rdy) break;
            @(negedge clk);
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(string tag, logic [4:0] a, logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 chk(tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic hdr(string tag, logic [47:0] d, logic [47:0] s,
                       logic exp_hit, logic [2:0] exp_idx);
        @(negedge clk);
        hdr_valid = 1'b1; hdr_dst_mac = d; hdr_src_mac = s;
        @(negedge clk);
        hdr_valid = 1'b0;
        chk({tag, " valid"}, 64'(match_valid), 64'(1));
        chk({tag, " hit"}, 64'(match_hit), 64'(exp_hit));
        chk({tag, " idx"}, 64'(match_idx), 64'(exp_hit ? exp_idx : 3'd0));
    endtask

    // R3, R10: no memory, all entries invalid, ready quickly, idle outputs.
    task automatic t_reset_no_nvm();
        do_reset(1'b0);
        @(negedge clk);
        chk("R3 ready after reset", 64'(reg_ready), 64'(1));
        chk("R10 idle match_valid", 64'(match_valid), 64'(0));
        chk("R10 idle match_hit", 64'(match_hit), 64'(0));
        for (int i = 0; i < 7; i++) rd("R3 entry high after reset", 5'(4*i+2), 32'h0);
        chk("R3 no memory reads", 64'(n_reads), 64'(0));
        hdr("R8 zero header vs invalid entries", 48'h0, 48'h0, 1'b0, 3'd0);
    endtask

    // R4, R5: load from memory, stalled write applied afterwards.
    task automatic t_load_and_stall();
        logic rdy;
        do_reset(1'b1);
        reg_wr = 1'b1; reg_addr = 5'd12; reg_wdata = 32'hDEAD_BEEF;
        #1;
        chk("R5 not ready during load", 64'(reg_ready), 64'(0));
        chk("R5 entry 3 untouched while stalled", 64'(reg_rdata), 64'(0));
        forever begin
            rdy = reg_ready;
            @(posedge clk);
            if (rdy) break;
            @(negedge clk);
        end
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R4 three reads", 64'(n_reads), 64'(3));
        chk("R4 word order", 64'({seen_addr[0], seen_addr[1], seen_addr[2]}),
            64'({2'd0, 2'd1, 2'd2}));
        rd("R5 stalled write applied", 5'd12, 32'hDEAD_BEEF);
        rd("R4 entry 0 low", 5'd0, {W1, W0});
        rd("R4 entry 0 high", 5'd2, {1'b1, 13'b0, 2'b00, W2});
        hdr("R6 station address on destination", STATION, 48'h1, 1'b1, 3'd0);
    endtask

    // R1, R2, R7: layout, reserved bits, reserved select codes.
    task automatic t_map_and_reserved();
        wr(5'd20, 32'hCAFE_F00D);
        wr(5'd22, 32'hFFFF_ABCD);
        rd("R2 reserved bits read zero", 5'd22, 32'h8003_ABCD);
        rd("R1 entry 5 low", 5'd20, 32'hCAFE_F00D);
        rd("R1 odd slot reads zero", 5'd21, 32'h0);
        wr(5'd29, 32'h1234_5678);
        rd("R1 unmapped slot reads zero", 5'd29, 32'h0);
        hdr("R7 select 11 never matches", 48'hABCD_CAFE_F00D, 48'hABCD_CAFE_F00D,
            1'b0, 3'd0);
        wr(5'd22, 32'h8002_ABCD);
        hdr("R7 select 10 never matches", 48'hABCD_CAFE_F00D, 48'hABCD_CAFE_F00D,
            1'b0, 3'd0);
    endtask

    // R6: source-select entry matches only on the source field.
    task automatic t_source_select();
        wr(5'd8, 32'h0102_0304);
        wr(5'd10, 32'h8001_0506);
        hdr("R6 source match", 48'h1, 48'h0506_0102_0304, 1'b1, 3'd2);
        hdr("R6 source entry ignores destination", 48'h0506_0102_0304, 48'h1,
            1'b0, 3'd0);
    endtask

    // R9, R8: priority between two equal entries, then disabling one.
    task automatic t_priority();
        wr(5'd16, 32'h7777_8888);
        wr(5'd18, 32'h8000_6666);
        wr(5'd24, 32'h7777_8888);
        wr(5'd26, 32'h8000_6666);
        hdr("R9 lowest index wins", 48'h6666_7777_8888, 48'h0, 1'b1, 3'd4);
        wr(5'd18, 32'h0000_6666);
        hdr("R8 invalid entry skipped", 48'h6666_7777_8888, 48'h0, 1'b1, 3'd6);
    endtask

    // R3: a later reset clears programmed valid flags.
    task automatic t_reset_clears();
        do_reset(1'b0);
        @(negedge clk);
        rd("R3 entry 6 invalid after reset", 5'd26, 32'h0);
        rd("R3 entry 0 invalid without memory", 5'd2, 32'h0);
        hdr("R3 no match after reset", 48'h6666_7777_8888, 48'h0, 1'b0, 3'd0);
    endtask

    initial begin
        t_reset_no_nvm();
        t_load_and_stall();
        t_map_and_reserved();
        t_source_select();
        t_priority();
        t_reset_clears();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule